// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits next to a small processor core and takes over the core's control flow whenever an interrupt is taken or a handler returns. At each instruction boundary it looks at a maskable request, a non-maskable request and an 8-bit type number. When it accepts an interrupt, it writes the core's flags, code segment and instruction pointer to the stack through a simple word-wide memory port. It then reads the handler's offset and segment from a vector table that starts at address zero, and hands the core a one-cycle redirect. The redirect carries the new code segment, the new instruction pointer, the new stack pointer and the flags with interrupt-enable cleared.

A return request runs the same port in reverse. It reads back the saved instruction pointer, code segment and flags, then redirects the core to the interrupted code with the stack pointer restored. Restoring the flags also restores the enable state the interrupted code had. The core holds its context inputs steady while `busy` is high and loads the redirect values in the cycle `redirect` is high.

The memory port returns read data in the cycle after the request cycle. Addresses are byte addresses and every access moves one 16-bit word. The interrupt-enable flag is bit 9 of the flags word.

Top module: `int_entry_seq`

## Requirements
- R1: While idle, no interrupt is accepted in a cycle where `instr_done` is low; `busy` stays low and no memory access is issued.
- R2: A maskable request is ignored while flags bit 9 (interrupt enable) is 0: no access is made, `busy` stays low and no redirect follows.
- R3: A non-maskable request is accepted whatever the value of bit 9. When both requests are present at a boundary, the non-maskable one wins and uses type 2 in place of `irq_type`.
- R4: After the pushes, the vector is read as two reads: the offset word at byte address type*4, then the segment word at type*4+2 (type 5 reads 0x14 then 0x16).
- R5: On entry, three writes are made in this order: flags to SP-2, code segment to SP-4, instruction pointer to SP-6. The redirect reports a new SP of SP-6.
- R6: On entry, `redirect` is a single-cycle pulse. With it, `new_ip` is the offset word, `new_cs` is the segment word and `new_flags` is the pushed flags with bit 9 cleared.
- R7: `busy` goes high the cycle after acceptance and stays high through the redirect cycle (7 cycles for an entry, 5 for a return), then falls. Memory requests occur only while `busy` is high.
- R8: A return request taken while idle reads the instruction pointer at SP, the code segment at SP+2 and the flags at SP+4, in that order. It redirects with those values and SP+6. It takes precedence over an interrupt request in the same cycle.
- R9: After reset, `busy`, `redirect` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | Current instruction retires this cycle (boundary) |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_type | input | 8 | Type number of the maskable request |
| iret_req | input | 1 | Return-from-handler request |
| cur_flags | input | 16 | Core flags word; bit 9 is interrupt enable |
| cur_cs | input | 16 | Core code segment |
| cur_ip | input | 16 | Return instruction pointer |
| cur_sp | input | 16 | Core stack pointer (byte address) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after the request |
| busy | output | 1 | Sequence in progress |
| redirect | output | 1 | One-cycle pulse: core loads the new_* values |
| new_flags | output | 16 | Flags for the core |
| new_cs | output | 16 | Code segment for the core |
| new_ip | output | 16 | Instruction pointer for the core |
| new_sp | output | 16 | Stack pointer for the core |

## Verification
The hardest case to reach is a return that restores state the block saved itself. That needs a full entry sequence first, then the core's stack pointer fed back from the redirect. The return must also arrive in the same cycle as a boundary with a live maskable request, so that precedence is tested too. The bench does this in order: it runs an entry and keeps the values that were pushed. It then raises the return, the boundary and an enabled maskable request together. It expects only reads, at the stack slots the entry wrote, and the original context back with interrupt-enable set again. The non-maskable-wins case is reached by raising both requests with enable clear and a type number other than 2, so that only the forced type can produce the vector reads that are seen.

// File: rtl/isq_pkg.sv
package isq_pkg;
   typedef enum logic [3:0] {
      S_IDLE,
      S_PUSH_FL,
      S_PUSH_CS,
      S_PUSH_IP,
      S_RD_OFF,
      S_RD_SEG,
      S_CAP_SEG,
      S_POP_IP,
      S_POP_CS,
      S_POP_FL,
      S_CAP_FL,
      S_JUMP
   } seq_state_e;
endpackage

// File: rtl/isq_arbiter.sv
module isq_arbiter #(
   parameter int TYPE_W   = 8,
   parameter int NMI_TYPE = 2
) (
   input  logic              idle,
   input  logic              instr_done,
   input  logic              irq_req,
   input  logic              nmi_req,
   input  logic              iret_req,
   input  logic              int_enable,
   input  logic [TYPE_W-1:0] irq_type,
   output logic              take_int,
   output logic              take_ret,
   output logic [TYPE_W-1:0] sel_type
);
   logic want_int;

   always_comb begin
      want_int = nmi_req | (irq_req & int_enable);
      take_ret = idle & iret_req;
      take_int = idle & instr_done & ~iret_req & want_int;
      sel_type = nmi_req ? TYPE_W'(NMI_TYPE) : irq_type;
   end
endmodule

// File: rtl/isq_seq.sv
module isq_seq
   import isq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take_int,
   input  logic       take_ret,
   output seq_state_e state,
   output logic       busy,
   output logic       redirect
);
   seq_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         S_IDLE:    if (take_ret) nxt = S_POP_IP;
                    else if (take_int) nxt = S_PUSH_FL;
         S_PUSH_FL: nxt = S_PUSH_CS;
         S_PUSH_CS: nxt = S_PUSH_IP;
         S_PUSH_IP: nxt = S_RD_OFF;
         S_RD_OFF:  nxt = S_RD_SEG;
         S_RD_SEG:  nxt = S_CAP_SEG;
         S_CAP_SEG: nxt = S_JUMP;
         S_POP_IP:  nxt = S_POP_CS;
         S_POP_CS:  nxt = S_POP_FL;
         S_POP_FL:  nxt = S_CAP_FL;
         S_CAP_FL:  nxt = S_JUMP;
         S_JUMP:    nxt = S_IDLE;
         default:   nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= S_IDLE;
      else        state <= nxt;
   end

   always_comb begin
      busy     = (state != S_IDLE);
      redirect = (state == S_JUMP);
   end

   assert_redirect_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> !redirect);

   assert_busy_ends_at_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(redirect));
endmodule

// File: rtl/isq_addr_gen.sv
module isq_addr_gen
   import isq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 16,
   parameter int TYPE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_e        state,
   input  logic [ADDR_W-1:0] sp_r,
   input  logic [WORD_W-1:0] flags_r,
   input  logic [WORD_W-1:0] cs_r,
   input  logic [WORD_W-1:0] ip_r,
   input  logic [TYPE_W-1:0] type_r,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata
);
   localparam int STEP    = WORD_W / 8;
   localparam int ENTRY_B = 2 * STEP;
   localparam int ENT_SH  = $clog2(ENTRY_B);
   localparam int PAD_W   = ADDR_W - TYPE_W - ENT_SH;

   logic [ADDR_W-1:0] vec_base;

   generate
      if (PAD_W > 0) begin : g_pad
         assign vec_base = {{PAD_W{1'b0}}, type_r, {ENT_SH{1'b0}}};
      end else begin : g_exact
         assign vec_base = {type_r, {ENT_SH{1'b0}}};
      end
   endgenerate

   always_comb begin
      mem_req   = 1'b1;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state)
         S_PUSH_FL: begin mem_we = 1'b1; mem_addr = sp_r - ADDR_W'(STEP);     mem_wdata = flags_r; end
         S_PUSH_CS: begin mem_we = 1'b1; mem_addr = sp_r - ADDR_W'(2 * STEP); mem_wdata = cs_r;    end
         S_PUSH_IP: begin mem_we = 1'b1; mem_addr = sp_r - ADDR_W'(3 * STEP); mem_wdata = ip_r;    end
         S_RD_OFF:  mem_addr = vec_base;
         S_RD_SEG:  mem_addr = vec_base + ADDR_W'(STEP);
         S_POP_IP:  mem_addr = sp_r;
         S_POP_CS:  mem_addr = sp_r + ADDR_W'(STEP);
         S_POP_FL:  mem_addr = sp_r + ADDR_W'(2 * STEP);
         default:   mem_req = 1'b0;
      endcase
   end

   assert_seg_after_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RD_SEG) |-> (mem_addr == $past(mem_addr) + ADDR_W'(STEP)));

   assert_push_descends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_PUSH_CS || state == S_PUSH_IP) |-> (mem_addr == $past(mem_addr) - ADDR_W'(STEP)));
endmodule

// File: rtl/isq_ctx.sv
module isq_ctx
   import isq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 16,
   parameter int TYPE_W = 8,
   parameter int IF_BIT = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_e        state,
   input  logic              take_int,
   input  logic              take_ret,
   input  logic [TYPE_W-1:0] sel_type,
   input  logic [WORD_W-1:0] cur_flags,
   input  logic [WORD_W-1:0] cur_cs,
   input  logic [WORD_W-1:0] cur_ip,
   input  logic [ADDR_W-1:0] cur_sp,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] sp_r,
   output logic [WORD_W-1:0] flags_r,
   output logic [WORD_W-1:0] cs_r,
   output logic [WORD_W-1:0] ip_r,
   output logic [TYPE_W-1:0] type_r,
   output logic [WORD_W-1:0] new_flags,
   output logic [WORD_W-1:0] new_cs,
   output logic [WORD_W-1:0] new_ip,
   output logic [ADDR_W-1:0] new_sp
);
   localparam int STEP = WORD_W / 8;
   localparam logic [WORD_W-1:0] IF_MASK = WORD_W'(1) << IF_BIT;

   logic ret_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_r    <= '0;
         flags_r <= '0;
         cs_r    <= '0;
         ip_r    <= '0;
         type_r  <= '0;
         ret_r   <= 1'b0;
      end else if (state == S_IDLE) begin
         if (take_ret) begin
            sp_r  <= cur_sp;
            ret_r <= 1'b1;
         end else if (take_int) begin
            sp_r    <= cur_sp;
            flags_r <= cur_flags;
            cs_r    <= cur_cs;
            ip_r    <= cur_ip;
            type_r  <= sel_type;
            ret_r   <= 1'b0;
         end
      end else begin
         unique case (state)
            S_RD_SEG:  ip_r    <= mem_rdata;
            S_CAP_SEG: cs_r    <= mem_rdata;
            S_POP_CS:  ip_r    <= mem_rdata;
            S_POP_FL:  cs_r    <= mem_rdata;
            S_CAP_FL:  flags_r <= mem_rdata;
            default:   ;
         endcase
      end
   end

   always_comb begin
      new_flags = ret_r ? flags_r : (flags_r & ~IF_MASK);
      new_cs    = cs_r;
      new_ip    = ip_r;
      new_sp    = ret_r ? (sp_r + ADDR_W'(3 * STEP)) : (sp_r - ADDR_W'(3 * STEP));
   end
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
   import isq_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int WORD_W   = 16,
   parameter int TYPE_W   = 8,
   parameter int IF_BIT   = 9,
   parameter int NMI_TYPE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_done,
   input  logic              irq_req,
   input  logic              nmi_req,
   input  logic [TYPE_W-1:0] irq_type,
   input  logic              iret_req,
   input  logic [WORD_W-1:0] cur_flags,
   input  logic [WORD_W-1:0] cur_cs,
   input  logic [WORD_W-1:0] cur_ip,
   input  logic [ADDR_W-1:0] cur_sp,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              busy,
   output logic              redirect,
   output logic [WORD_W-1:0] new_flags,
   output logic [WORD_W-1:0] new_cs,
   output logic [WORD_W-1:0] new_ip,
   output logic [ADDR_W-1:0] new_sp
);
   localparam int ENTRY_B = 2 * (WORD_W / 8);

   generate
      if (WORD_W % 8 != 0 || (ENTRY_B & (ENTRY_B - 1)) != 0) begin : g_bad_word
         $error("WORD_W must be a byte multiple giving a power-of-two entry size");
      end
      if (IF_BIT >= WORD_W) begin : g_bad_if
         $error("IF_BIT must lie inside the flags word");
      end
      if (ADDR_W < TYPE_W + $clog2(ENTRY_B)) begin : g_bad_addr
         $error("ADDR_W too narrow for the vector table");
      end
      if (NMI_TYPE >= (1 << TYPE_W)) begin : g_bad_nmi
         $error("NMI_TYPE out of range");
      end
   endgenerate

   seq_state_e        state;
   logic              take_int, take_ret;
   logic [TYPE_W-1:0] sel_type, type_r;
   logic [ADDR_W-1:0] sp_r;
   logic [WORD_W-1:0] flags_r, cs_r, ip_r;

   isq_arbiter #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)) u_arb (
      .idle       (state == S_IDLE),
      .instr_done (instr_done),
      .irq_req    (irq_req),
      .nmi_req    (nmi_req),
      .iret_req   (iret_req),
      .int_enable (cur_flags[IF_BIT]),
      .irq_type   (irq_type),
      .take_int   (take_int),
      .take_ret   (take_ret),
      .sel_type   (sel_type)
   );

   isq_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_int (take_int),
      .take_ret (take_ret),
      .state    (state),
      .busy     (busy),
      .redirect (redirect)
   );

   isq_ctx #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .TYPE_W(TYPE_W), .IF_BIT(IF_BIT)) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .take_int  (take_int),
      .take_ret  (take_ret),
      .sel_type  (sel_type),
      .cur_flags (cur_flags),
      .cur_cs    (cur_cs),
      .cur_ip    (cur_ip),
      .cur_sp    (cur_sp),
      .mem_rdata (mem_rdata),
      .sp_r      (sp_r),
      .flags_r   (flags_r),
      .cs_r      (cs_r),
      .ip_r      (ip_r),
      .type_r    (type_r),
      .new_flags (new_flags),
      .new_cs    (new_cs),
      .new_ip    (new_ip),
      .new_sp    (new_sp)
   );

   isq_addr_gen #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .TYPE_W(TYPE_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .sp_r      (sp_r),
      .flags_r   (flags_r),
      .cs_r      (cs_r),
      .ip_r      (ip_r),
      .type_r    (type_r),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   assert_wait_for_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !instr_done && !iret_req) |=> !busy);

   assert_masked_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !iret_req && !nmi_req && !cur_flags[IF_BIT]) |=> !busy);

   assert_nmi_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && instr_done && nmi_req) |=> busy);

   assert_mem_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
endmodule

// File: tb/tb_int_entry_seq.sv
`timescale 1ns/1ps
module tb_int_entry_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_done = 1'b0, irq_req = 1'b0, nmi_req = 1'b0, iret_req = 1'b0;
   logic [7:0]  irq_type = '0;
   logic [15:0] cur_flags = '0, cur_cs = '0, cur_ip = '0, cur_sp = '0;
   logic        mem_req, mem_we, busy, redirect;
   logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic [15:0] new_flags, new_cs, new_ip, new_sp;

   int n_tests = 0;
   int n_fail  = 0;
   int log_n   = 0;
   logic [15:0] log_addr [64];
   logic        log_we   [64];
   logic [15:0] ram      [1024];

   always #5 clk = ~clk;

   int_entry_seq dut (.*);

   function automatic logic [15:0] vec_word(input logic [15:0] a);
      logic [7:0] t;
      t = a[9:2];
      return a[1] ? (16'h5000 + {8'h00, t}) : (16'hA000 ^ {8'h00, t});
   endfunction

   always @(posedge clk) begin
      if (mem_req) begin
         log_addr[log_n[5:0]] <= mem_addr;
         log_we[log_n[5:0]]   <= mem_we;
         log_n <= log_n + 1;
         if (mem_we) ram[mem_addr[10:1]] <= mem_wdata;
         else if (mem_addr < 16'h0400) mem_rdata <= vec_word(mem_addr);
         else mem_rdata <= ram[mem_addr[10:1]];
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // Wait for the redirect, checking busy each cycle; returns the cycle count.
   task automatic wait_redirect(input string rq, output int lat);
      lat = 1;
      while (!redirect && lat < 20) begin
         chk(busy === 1'b1, rq, busy, 1);
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic run_entry(input bit nmi, input bit irq, input bit ifl, input logic [7:0] typ,
                            input logic [15:0] sp, input bit acc, input logic [7:0] etyp);
      int s, lat;
      logic [15:0] fl, cs, ip, va;
      fl = ifl ? 16'h02C5 : 16'h00C5;
      cs = 16'h1234 + {8'h00, typ};
      ip = 16'h0100 + {8'h00, typ};
      cur_flags = fl; cur_cs = cs; cur_ip = ip; cur_sp = sp;
      s = log_n;
      instr_done = 1'b1; nmi_req = nmi; irq_req = irq; irq_type = typ;
      @(negedge clk);
      instr_done = 1'b0; nmi_req = 1'b0; irq_req = 1'b0;
      if (!acc) begin
         for (int k = 0; k < 3; k++) begin
            chk(busy === 1'b0 && redirect === 1'b0, "R2 masked request ignored", busy, 0);
            @(negedge clk);
         end
         chk(log_n == s, "R2 no memory access when masked", log_n - s, 0);
         return;
      end
      wait_redirect("R7 busy until redirect", lat);
      chk(lat == 7, "R7 entry latency", lat, 7);
      va = {6'h00, etyp, 2'b00};
      chk(new_ip == (16'hA000 ^ {8'h00, etyp}), "R6/R3 new_ip from vector", new_ip, 16'hA000 ^ {8'h00, etyp});
      chk(new_cs == (16'h5000 + {8'h00, etyp}), "R6/R3 new_cs from vector", new_cs, 16'h5000 + {8'h00, etyp});
      chk(new_flags == (fl & 16'hFDFF), "R6 enable cleared", new_flags, fl & 16'hFDFF);
      chk(new_sp == sp - 16'd6, "R5 new sp", new_sp, sp - 16'd6);
      @(negedge clk);
      chk(busy === 1'b0 && redirect === 1'b0, "R6 redirect single pulse", {busy, redirect}, 0);
      chk(log_n == s + 5, "R5 access count", log_n - s, 5);
      chk(log_addr[(s)   & 63] == sp - 16'd2 && log_we[(s) & 63],   "R5 flags push addr", log_addr[s & 63], sp - 16'd2);
      chk(log_addr[(s+1) & 63] == sp - 16'd4 && log_we[(s+1) & 63], "R5 cs push addr", log_addr[(s+1) & 63], sp - 16'd4);
      chk(log_addr[(s+2) & 63] == sp - 16'd6 && log_we[(s+2) & 63], "R5 ip push addr", log_addr[(s+2) & 63], sp - 16'd6);
      chk(ram[(sp - 16'd2) >> 1] == fl, "R5 flags pushed", ram[(sp - 16'd2) >> 1], fl);
      chk(ram[(sp - 16'd4) >> 1] == cs, "R5 cs pushed", ram[(sp - 16'd4) >> 1], cs);
      chk(ram[(sp - 16'd6) >> 1] == ip, "R5 ip pushed", ram[(sp - 16'd6) >> 1], ip);
      chk(log_addr[(s+3) & 63] == va && !log_we[(s+3) & 63], "R4 offset read at type*4", log_addr[(s+3) & 63], va);
      chk(log_addr[(s+4) & 63] == va + 16'd2 && !log_we[(s+4) & 63], "R4 segment read at type*4+2", log_addr[(s+4) & 63], va + 16'd2);
   endtask

   typedef struct packed {
      logic        nmi;
      logic        irq;
      logic        ifl;
      logic [7:0]  typ;
      logic [15:0] sp;
      logic        acc;
      logic [7:0]  etyp;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{1'b0, 1'b1, 1'b1, 8'd5,   16'h07F0, 1'b1, 8'd5},
      '{1'b1, 1'b0, 1'b0, 8'h33,  16'h0780, 1'b1, 8'd2},
      '{1'b1, 1'b1, 1'b0, 8'd7,   16'h0760, 1'b1, 8'd2},
      '{1'b0, 1'b1, 1'b1, 8'd255, 16'h0740, 1'b1, 8'd255},
      '{1'b0, 1'b1, 1'b0, 8'd9,   16'h0720, 1'b0, 8'd0},
      '{1'b0, 1'b1, 1'b1, 8'd0,   16'h0700, 1'b1, 8'd0},
      '{1'b1, 1'b0, 1'b1, 8'd2,   16'h06E0, 1'b1, 8'd2}
   };

   initial begin
      #(200000 * 10);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int s, lat;
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && redirect === 1'b0 && mem_req === 1'b0, "R9 reset state", {busy, redirect, mem_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: stimulus and expected result per row (R2, R3, R4, R5, R6)
      foreach (VECS[i]) begin
         run_entry(VECS[i].nmi, VECS[i].irq, VECS[i].ifl, VECS[i].typ, VECS[i].sp, VECS[i].acc, VECS[i].etyp);
         @(negedge clk);
      end

      // R1: enabled request without an instruction boundary is held off
      s = log_n;
      cur_flags = 16'h0200; irq_req = 1'b1; nmi_req = 1'b1; irq_type = 8'd4;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(busy === 1'b0, "R1 no entry without boundary", busy, 0);
      end
      irq_req = 1'b0; nmi_req = 1'b0;
      chk(log_n == s, "R1 no access without boundary", log_n - s, 0);

      // R8: entry, then return together with a boundary and enabled request
      run_entry(1'b0, 1'b1, 1'b1, 8'd9, 16'h07C0, 1'b1, 8'd9);
      @(negedge clk);
      s = log_n;
      cur_sp = 16'h07BA; cur_flags = 16'h0000; cur_cs = 16'hDEAD; cur_ip = 16'hBEEF;
      iret_req = 1'b1; instr_done = 1'b1; irq_req = 1'b1; irq_type = 8'd6;
      cur_flags = 16'h0200;
      @(negedge clk);
      iret_req = 1'b0; instr_done = 1'b0; irq_req = 1'b0;
      wait_redirect("R8 busy during return", lat);
      chk(lat == 5, "R8 return latency", lat, 5);
      chk(new_ip == 16'h0109, "R8 ip restored", new_ip, 16'h0109);
      chk(new_cs == 16'h123D, "R8 cs restored", new_cs, 16'h123D);
      chk(new_flags == 16'h02C5, "R8 flags restored with enable", new_flags, 16'h02C5);
      chk(new_sp == 16'h07C0, "R8 sp restored", new_sp, 16'h07C0);
      @(negedge clk);
      chk(busy === 1'b0, "R7 idle after return", busy, 0);
      chk(log_n == s + 3, "R8 only three pops", log_n - s, 3);
      chk(log_addr[s & 63] == 16'h07BA && !log_we[s & 63], "R8 pop ip at sp", log_addr[s & 63], 16'h07BA);
      chk(log_addr[(s+1) & 63] == 16'h07BC && !log_we[(s+1) & 63], "R8 pop cs at sp+2", log_addr[(s+1) & 63], 16'h07BC);
      chk(log_addr[(s+2) & 63] == 16'h07BE && !log_we[(s+2) & 63], "R8 pop flags at sp+4", log_addr[(s+2) & 63], 16'h07BE);

      // R9: reset in the middle of a sequence
      cur_flags = 16'h0200; cur_sp = 16'h07A0;
      instr_done = 1'b1; irq_req = 1'b1; irq_type = 8'd1;
      @(negedge clk);
      instr_done = 1'b0; irq_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(busy === 1'b0 && redirect === 1'b0 && mem_req === 1'b0, "R9 reset mid-sequence", {busy, redirect, mem_req}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0, "R9 idle after reset", busy, 0);

      finish_run();
   end
endmodule